// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block sets the order in which the frame-fetch DMA engine and the pixel-output core of an LCD controller are switched on and off. A single power request drives the sequence. On power-up the sequencer waits for the DMA engine to report idle, then enables it and pulses a configuration-load strobe in the same cycle. It then counts a programmable number of frame-start pulses and waits for the core to report idle. Only after that does it enable the core.

On power-down the core is switched off first and the DMA one cycle later. Dropping the request before the core is on cancels the sequence and returns straight to idle. A status code reports the current phase.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After synchronous reset, `dma_en`, `core_en` and `cfg_load` are 0 and `status` is 0 (idle).
- R2: A high `pwr_req` in idle moves `status` to 1 (waiting for DMA) at the next edge. `dma_en` stays low for as long as `dma_busy` is high.
- R3: In status 1, the first edge with `dma_busy` low and `pwr_req` high raises `dma_en` and `cfg_load` together. `cfg_load` is high for exactly that one cycle.
- R4: `guard_frames` is captured at the edge that enables the DMA. The core is held off until that many `frame_start` pulses have been seen after that edge. A pulse in the capture cycle does not count, and later changes to `guard_frames` have no effect. `status` is 2 during this guard phase.
- R5: `core_en` rises only at an edge where `core_busy` is low. While the guard has expired but the core is busy, `status` stays 2.
- R6: `core_en` is never high unless `dma_en` is high.
- R7: Dropping `pwr_req` while `status` is 3 (on) clears `core_en` at the next edge with `status` 4 (stopping). The edge after that clears `dma_en` and returns `status` to 0.
- R8: Dropping `pwr_req` while `status` is 1 or 2 returns `status` to 0 at the next edge, with `dma_en` low and `core_en` never raised.
- R9: With a captured guard of 0 and `core_busy` low, `core_en` rises at the edge right after the one that raised `dma_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Request for the panel to be powered |
| dma_busy | input | 1 | Frame-fetch DMA engine is busy |
| core_busy | input | 1 | Pixel-output core is busy |
| frame_start | input | 1 | One-cycle pulse at each frame start |
| guard_frames | input | GUARD_W | Guard delay in frames |
| dma_en | output | 1 | DMA engine enable |
| cfg_load | output | 1 | One-cycle DMA configuration-load strobe |
| core_en | output | 1 | Pixel-output core enable |
| status | output | 3 | 0 idle, 1 wait DMA, 2 guard, 3 on, 4 stopping |

## Verification
A full power-up and power-down cycle is run with DMA busy held for several cycles, frame pulses spaced irregularly, one pulse landing in the capture cycle, and core busy asserted after the guard has expired. These cases separate a counter that misses the load priority, or that counts early, from a correct one, and they show whether the core gate reads the busy flag. Directed runs cover a zero guard, cancellation in each pre-on phase, and a guard value changed mid-count. These separate a captured guard from a live one and an abort from a normal shutdown.

// File: rtl/lcd_pwr_seq_pkg.sv
package lcd_pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_DMA = 3'd1,
    ST_GUARD    = 3'd2,
    ST_ON       = 3'd3,
    ST_STOP     = 3'd4
  } seq_state_t;
endpackage

// File: rtl/lcd_pwr_guard.sv
module lcd_pwr_guard #(
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [GUARD_W-1:0] load_val,
  input  logic               tick,
  output logic               done
);
  logic [GUARD_W-1:0] cnt_q;

  // load wins over a tick in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> done); // R4
endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
  import lcd_pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_req,
  input  logic       dma_busy,
  input  logic       core_busy,
  input  logic       guard_done,
  output logic       guard_load,
  output logic       dma_en,
  output logic       cfg_load,
  output logic       core_en,
  output logic [2:0] status
);
  seq_state_t st_q;

  assign guard_load = (st_q == ST_WAIT_DMA) && pwr_req && !dma_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      dma_en   <= 1'b0;
      core_en  <= 1'b0;
      cfg_load <= 1'b0;
    end else begin
      cfg_load <= 1'b0;
      case (st_q)
        ST_IDLE: if (pwr_req) st_q <= ST_WAIT_DMA;
        ST_WAIT_DMA: begin
          if (!pwr_req) st_q <= ST_IDLE;
          else if (!dma_busy) begin
            st_q     <= ST_GUARD;
            dma_en   <= 1'b1;
            cfg_load <= 1'b1;
          end
        end
        ST_GUARD: begin
          if (!pwr_req) begin
            st_q   <= ST_IDLE;
            dma_en <= 1'b0;
          end else if (guard_done && !core_busy) begin
            st_q    <= ST_ON;
            core_en <= 1'b1;
          end
        end
        ST_ON: if (!pwr_req) begin
          st_q    <= ST_STOP;
          core_en <= 1'b0;
        end
        ST_STOP: begin
          st_q   <= ST_IDLE;
          dma_en <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign status = st_q;

  AST_CORE_NEEDS_DMA: assert property (@(posedge clk) disable iff (rst)
    core_en |-> dma_en); // R6
  AST_CORE_OFF_FIRST: assert property (@(posedge clk) disable iff (rst)
    $fell(dma_en) |-> !$past(core_en)); // R7
  AST_LOAD_WITH_DMA: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> $rose(dma_en)); // R3
  AST_CORE_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(core_en) |-> !$past(core_busy)); // R5
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_req,
  input  logic               dma_busy,
  input  logic               core_busy,
  input  logic               frame_start,
  input  logic [GUARD_W-1:0] guard_frames,
  output logic               dma_en,
  output logic               cfg_load,
  output logic               core_en,
  output logic [2:0]         status
);
  logic guard_load, guard_done;

  lcd_pwr_guard #(.GUARD_W(GUARD_W)) u_guard (
    .clk(clk), .rst(rst), .load(guard_load), .load_val(guard_frames),
    .tick(frame_start), .done(guard_done)
  );

  lcd_pwr_fsm u_fsm (
    .clk(clk), .rst(rst), .pwr_req(pwr_req), .dma_busy(dma_busy),
    .core_busy(core_busy), .guard_done(guard_done), .guard_load(guard_load),
    .dma_en(dma_en), .cfg_load(cfg_load), .core_en(core_en), .status(status)
  );
endmodule

// File: tb/lcd_pwr_seq_bench.sv
module lcd_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {req, dma_busy, core_busy, frame_start, exp_dma, exp_core, exp_load, exp_status[2:0]}
  localparam logic [9:0] VEC [NV] = '{
    10'b0000_000_000, 10'b1100_000_001, 10'b1100_000_001,
    10'b1001_101_010, 10'b1001_100_010, 10'b1000_100_010,
    10'b1001_100_010, 10'b1010_100_010, 10'b1000_110_011,
    10'b1001_110_011, 10'b0000_100_100, 10'b0000_000_000
  };

  logic clk = 0, rst = 1, pwr_req = 0, dma_busy = 0, core_busy = 0, frame_start = 0;
  logic [7:0] guard_frames = 8'd2;
  logic dma_en, cfg_load, core_en;
  logic [2:0] status;
  int checks = 0, errors = 0, cyc = 0;

  lcd_pwr_seq u_lcd_pwr_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got dma/core/load/st=%b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {dma_en, core_en, cfg_load, status};
  endfunction

  task automatic drive(logic r, logic db, logic cb, logic fs);
    pwr_req = r; dma_busy = db; core_busy = cb; frame_start = fs;
  endtask

  initial begin
    step(); step();
    chk("R1 reset", outs(), 6'b000_000);
    rst = 0;
    // R2 R3 R4 R5 R7 table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      step();
      chk($sformatf("R2/R3/R4/R5/R7 vec %0d", i), outs(), VEC[i][5:0]);
    end
    // R9 zero guard
    guard_frames = 0;
    drive(1,0,0,0); step(); step();
    chk("R9 dma on", outs(), 6'b101_010);
    step();
    chk("R9 core next edge", outs(), 6'b110_011);
    drive(0,0,0,0); step(); step();
    chk("R7 back idle", outs(), 6'b000_000);
    // R8 abort in guard
    guard_frames = 3;
    drive(1,0,0,0); step(); step(); drive(1,0,0,1); step();
    drive(0,0,0,0); step();
    chk("R8 abort guard", outs(), 6'b000_000);
    // R8 abort in wait-for-DMA
    drive(1,1,0,0); step();
    chk("R2 wait dma", outs(), 6'b000_001);
    drive(0,1,0,0); step();
    chk("R8 abort wait", outs(), 6'b000_000);
    // R4 guard change after capture ignored
    guard_frames = 1;
    drive(1,0,0,0); step(); step();
    guard_frames = 0;
    step(); step();
    chk("R4 captured guard held", outs(), 6'b100_010);
    drive(1,0,0,1); step(); drive(1,0,0,0);
    chk("R4 guard counting", outs(), 6'b100_010);
    step();
    chk("R4 core after pulse", outs(), 6'b110_011);
    drive(0,0,0,0); step();
    chk("R7 core off first", outs(), 6'b100_100);
    step();
    chk("R7 dma off second", outs(), 6'b000_000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule